// File: doc/BRIEF.md
# Post-Wake Register Patch Sequencer

When the device comes out of its low-power sleep, the volatile configuration RAM holds nothing useful. A small battery-backed RAM, by contrast, keeps its contents across sleep. This block rebuilds the needed register overrides in the volatile RAM after every wake-up, before the receiver is put to use.

A single wake pulse starts the block. It first fetches a pointer byte from a fixed location in the retained RAM. The pointer gives the low byte of the start of a patch list, and the list sits in the same 256-byte page as the pointer location. Each list entry is two bytes: an address byte, then the data byte to store. The block writes each data byte into the volatile RAM at a fixed page base plus the address byte. An address byte of zero ends the list.

Two guards keep a run bounded. An entry limit stops a list that has no terminator and raises an error flag. List addresses wrap inside the retained RAM, so no read can go past its end. Both memories sit outside the block. The retained RAM is reached through a read port whose data is valid one cycle after the request, and the volatile RAM through a write strobe.

Top module: `wake_patch_seq`

## Requirements
- R1: While reset is held and right after it, busy_o, done_o, err_o, ret_rd_en_o and cfg_wr_en_o are all low.
- R2: In the cycle after a wake_i sampled while idle, busy_o is high and a retained read of address PTR_LOC is requested.
- R3: A pointer byte of 0x00 applies no patches, and done_o pulses in the third cycle after the wake edge.
- R4: The list base is the page of PTR_LOC (address bits above bit 7) with the pointer byte as its low 8 bits. Entry k sits at base+2k (address byte) and base+2k+1 (data byte).
- R5: Each patch writes the data byte at CFG_PAGE plus the address byte, in list order, one write per entry.
- R6: An address byte of 0x00 ends the run with no write. A run of n entries pulses done_o 4n+5 cycles after the wake edge.
- R7: At most MAX_ENTRIES writes are made. If the slot after them holds a nonzero address byte, the run ends at the same 4n+5 timing with err_o high. A zero there ends the run cleanly.
- R8: A wake_i that arrives while a run is busy is ignored. It does not restart the run, and the writes and timing stay unchanged.
- R9: busy_o stays high from the cycle after the accepted wake until the done cycle, and it is low in the done cycle.
- R10: err_o holds its value after a run ends and is cleared only by the next accepted wake.
- R11: List addresses are computed modulo 2^RET_AW, so a list near the top of the retained RAM continues at address 0.
- R12: done_o lasts exactly one cycle and never coincides with cfg_wr_en_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wake_i | input | 1 | Wake pulse that starts a patch run |
| ret_rd_en_o | output | 1 | Retained RAM read request |
| ret_rd_addr_o | output | RET_AW | Retained RAM read address |
| ret_rd_data_i | input | 8 | Retained RAM read data, valid one cycle after the request |
| cfg_wr_en_o | output | 1 | Volatile RAM write strobe |
| cfg_wr_addr_o | output | CFG_AW | Volatile RAM write address |
| cfg_wr_data_o | output | 8 | Volatile RAM write data |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| err_o | output | 1 | Last run hit the entry limit without a terminator |

## Verification
The bench builds the block with MAX_ENTRIES = 4, so both outcomes at the limit can be reached in a handful of short runs: a full list that is cleanly terminated, and an overlong list that ends in the error flag. The retained RAM is 9 bits wide (512 bytes), with the pointer at 0x128 and the volatile page at 0x300 on a 10-bit address. This lets a list that starts at 0x1FE cross the top of the memory and continue at 0x000. The same layout also reproduces the three-write reference run, with its exact cycle count.

// File: rtl/wps_pkg.sv
package wps_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ_PTR,
    ST_GET_PTR,
    ST_REQ_ADR,
    ST_GET_ADR,
    ST_REQ_DAT,
    ST_GET_DAT,
    ST_FIN
  } wps_state_e;

  typedef enum logic [1:0] {
    SEL_PTR,
    SEL_ADR,
    SEL_DAT
  } wps_sel_e;

endpackage

// File: rtl/wps_list_addr.sv
module wps_list_addr
  import wps_pkg::*;
#(
  parameter int RET_AW  = 9,
  parameter int PTR_LOC = 'h128,
  parameter int IDX_W   = 7
) (
  input  wps_sel_e            sel_i,
  input  logic [BYTE_W-1:0]   base_lo_i,
  input  logic [IDX_W-1:0]    idx_i,
  output logic [RET_AW-1:0]   addr_o
);

  localparam logic [RET_AW-1:0] PTR_A = RET_AW'(PTR_LOC);
  localparam int PAGE_W = RET_AW - BYTE_W;

  // list base: page of the pointer location, pointer byte as low part
  function automatic logic [RET_AW-1:0] list_base(input logic [BYTE_W-1:0] lo);
    return {PTR_A[RET_AW-1:BYTE_W], lo};
  endfunction

  // slot address of entry idx, byte odd (0 = address byte, 1 = data byte),
  // wrapped within the retained space
  function automatic logic [RET_AW-1:0] slot_addr(input logic [BYTE_W-1:0] lo,
                                                  input logic [IDX_W-1:0] idx,
                                                  input logic odd);
    logic [31:0] sum;
    sum = 32'(list_base(lo)) + (32'(idx) << 1) + 32'(odd);
    return sum[RET_AW-1:0];
  endfunction

  generate
    if (PAGE_W < 1) begin : g_bad_width
      initial $display("wps_list_addr: RET_AW must exceed 8");
    end
  endgenerate

  always_comb begin
    unique case (sel_i)
      SEL_ADR: addr_o = slot_addr(base_lo_i, idx_i, 1'b0);
      SEL_DAT: addr_o = slot_addr(base_lo_i, idx_i, 1'b1);
      default: addr_o = PTR_A;
    endcase
  end

endmodule

// File: rtl/wps_entry_ctr.sv
module wps_entry_ctr #(
  parameter int MAX_ENTRIES = 64,
  parameter int CNT_W       = $clog2(MAX_ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             at_limit_o
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_ENTRIES);

  assign at_limit_o = (cnt_o == LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      cnt_o <= '0;
    end else if (inc_i && !at_limit_o) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end

endmodule

// File: rtl/wps_ctrl.sv
module wps_ctrl
  import wps_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wake_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  input  logic              at_limit_i,
  output logic              rd_en_o,
  output wps_sel_e          sel_o,
  output logic [BYTE_W-1:0] base_lo_o,
  output logic [BYTE_W-1:0] adr_lo_o,
  output logic              wr_en_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              err_o,
  output logic              cnt_clr_o,
  output logic              cnt_inc_o,
  output logic              wake_take_o,
  output logic              ptr_zero_o,
  output logic              list_end_o,
  output logic              overflow_o
);

  wps_state_e state_q, state_d;
  logic       byte_zero;

  assign byte_zero   = (rd_data_i == '0);
  assign wake_take_o = (state_q == ST_IDLE) && wake_i;
  assign ptr_zero_o  = (state_q == ST_GET_PTR) && byte_zero;
  assign list_end_o  = (state_q == ST_GET_ADR) && byte_zero;
  assign overflow_o  = (state_q == ST_GET_ADR) && !byte_zero && at_limit_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (wake_i) state_d = ST_REQ_PTR;
      ST_REQ_PTR: state_d = ST_GET_PTR;
      ST_GET_PTR: state_d = byte_zero ? ST_FIN : ST_REQ_ADR;
      ST_REQ_ADR: state_d = ST_GET_ADR;
      ST_GET_ADR: state_d = (byte_zero || at_limit_i) ? ST_FIN : ST_REQ_DAT;
      ST_REQ_DAT: state_d = ST_GET_DAT;
      ST_GET_DAT: state_d = ST_REQ_ADR;
      ST_FIN:     state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_q)
      ST_REQ_ADR: sel_o = SEL_ADR;
      ST_REQ_DAT: sel_o = SEL_DAT;
      default:    sel_o = SEL_PTR;
    endcase
  end

  assign rd_en_o   = (state_q == ST_REQ_PTR) || (state_q == ST_REQ_ADR) ||
                     (state_q == ST_REQ_DAT);
  assign wr_en_o   = (state_q == ST_GET_DAT);
  assign done_o    = (state_q == ST_FIN);
  assign busy_o    = (state_q != ST_IDLE) && (state_q != ST_FIN);
  assign cnt_clr_o = wake_take_o;
  assign cnt_inc_o = wr_en_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      base_lo_o <= '0;
      adr_lo_o  <= '0;
      err_o     <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_GET_PTR) base_lo_o <= rd_data_i;
      if (state_q == ST_GET_ADR) adr_lo_o  <= rd_data_i;
      if (wake_take_o)     err_o <= 1'b0;
      else if (overflow_o) err_o <= 1'b1;
    end
  end

endmodule

// File: rtl/wake_patch_seq.sv
module wake_patch_seq
  import wps_pkg::*;
#(
  parameter int RET_AW      = 9,
  parameter int PTR_LOC     = 'h128,
  parameter int CFG_AW      = 10,
  parameter int CFG_PAGE    = 'h300,
  parameter int MAX_ENTRIES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wake_i,
  output logic              ret_rd_en_o,
  output logic [RET_AW-1:0] ret_rd_addr_o,
  input  logic [7:0]        ret_rd_data_i,
  output logic              cfg_wr_en_o,
  output logic [CFG_AW-1:0] cfg_wr_addr_o,
  output logic [7:0]        cfg_wr_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);

  localparam int CNT_W = $clog2(MAX_ENTRIES + 1);

  // volatile write address: fixed page plus the entry's address byte
  function automatic logic [CFG_AW-1:0] cfg_target(input logic [BYTE_W-1:0] lo);
    return CFG_AW'(CFG_PAGE) + CFG_AW'(lo);
  endfunction

  wps_sel_e          rd_sel_w;
  logic [BYTE_W-1:0] base_lo_w;
  logic [BYTE_W-1:0] adr_lo_w;
  logic [CNT_W-1:0]  entry_cnt_w;
  logic              at_limit_w;
  logic              cnt_clr_w;
  logic              cnt_inc_w;
  logic              wake_take_w;
  logic              ptr_zero_w;
  logic              list_end_w;
  logic              overflow_w;

  wps_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wake_i      (wake_i),
    .rd_data_i   (ret_rd_data_i),
    .at_limit_i  (at_limit_w),
    .rd_en_o     (ret_rd_en_o),
    .sel_o       (rd_sel_w),
    .base_lo_o   (base_lo_w),
    .adr_lo_o    (adr_lo_w),
    .wr_en_o     (cfg_wr_en_o),
    .done_o      (done_o),
    .busy_o      (busy_o),
    .err_o       (err_o),
    .cnt_clr_o   (cnt_clr_w),
    .cnt_inc_o   (cnt_inc_w),
    .wake_take_o (wake_take_w),
    .ptr_zero_o  (ptr_zero_w),
    .list_end_o  (list_end_w),
    .overflow_o  (overflow_w)
  );

  wps_entry_ctr #(
    .MAX_ENTRIES (MAX_ENTRIES),
    .CNT_W       (CNT_W)
  ) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (cnt_clr_w),
    .inc_i      (cnt_inc_w),
    .cnt_o      (entry_cnt_w),
    .at_limit_o (at_limit_w)
  );

  wps_list_addr #(
    .RET_AW  (RET_AW),
    .PTR_LOC (PTR_LOC),
    .IDX_W   (CNT_W)
  ) u_addr (
    .sel_i     (rd_sel_w),
    .base_lo_i (base_lo_w),
    .idx_i     (entry_cnt_w),
    .addr_o    (ret_rd_addr_o)
  );

  assign cfg_wr_addr_o = cfg_target(adr_lo_w);
  assign cfg_wr_data_o = ret_rd_data_i;

endmodule

// File: rtl/wps_chk.sv
module wps_chk #(
  parameter int RET_AW      = 9,
  parameter int PTR_LOC     = 'h128,
  parameter int CFG_AW      = 10,
  parameter int CFG_PAGE    = 'h300,
  parameter int MAX_ENTRIES = 64,
  parameter int CNT_W       = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wake_i,
  input logic              ret_rd_en_o,
  input logic [RET_AW-1:0] ret_rd_addr_o,
  input logic              cfg_wr_en_o,
  input logic [CFG_AW-1:0] cfg_wr_addr_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic              wake_take_w,
  input logic              ptr_zero_w,
  input logic              list_end_w,
  input logic              overflow_w,
  input logic [CNT_W-1:0]  entry_cnt_w
);

  localparam logic [RET_AW-1:0] PTR_A = RET_AW'(PTR_LOC);
  localparam logic [CFG_AW-1:0] CFG_A = CFG_AW'(CFG_PAGE);
  localparam logic [CNT_W-1:0]  LIMIT = CNT_W'(MAX_ENTRIES);

  // R2
  wake_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_take_w |=> busy_o && ret_rd_en_o && ret_rd_addr_o == PTR_A);

  // R3
  ptr_zero_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_zero_w |=> done_o && !cfg_wr_en_o);

  // R5
  wr_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en_o |-> cfg_wr_addr_o[CFG_AW-1:8] == CFG_A[CFG_AW-1:8] && $past(ret_rd_en_o));

  // R6
  wr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en_o |-> cfg_wr_addr_o[7:0] != 8'h00);

  // R6
  list_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    list_end_w |=> done_o && !err_o);

  // R7
  overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_w |=> done_o && err_o);

  // R7
  wr_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en_o |-> entry_cnt_w < LIMIT);

  // R9
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(wake_i));

  // R9
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  // R10
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> done_o);

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R12
  wr_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr_en_o && done_o));

endmodule

bind wake_patch_seq wps_chk #(
  .RET_AW      (RET_AW),
  .PTR_LOC     (PTR_LOC),
  .CFG_AW      (CFG_AW),
  .CFG_PAGE    (CFG_PAGE),
  .MAX_ENTRIES (MAX_ENTRIES),
  .CNT_W       (CNT_W)
) u_wps_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wake_i        (wake_i),
  .ret_rd_en_o   (ret_rd_en_o),
  .ret_rd_addr_o (ret_rd_addr_o),
  .cfg_wr_en_o   (cfg_wr_en_o),
  .cfg_wr_addr_o (cfg_wr_addr_o),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .err_o         (err_o),
  .wake_take_w   (wake_take_w),
  .ptr_zero_w    (ptr_zero_w),
  .list_end_w    (list_end_w),
  .overflow_w    (overflow_w),
  .entry_cnt_w   (entry_cnt_w)
);

// File: tb/wake_patch_seq_test.sv
`timescale 1ns/1ps
module wake_patch_seq_test;

  localparam int RET_AW  = 9;
  localparam int CFG_AW  = 10;
  localparam int PTR_LOC = 'h128;
  localparam int MAXE    = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wake = 1'b0;
  logic              rd_en;
  logic [RET_AW-1:0] rd_addr;
  logic [7:0]        rd_data = '0;
  logic              wr_en;
  logic [CFG_AW-1:0] wr_addr;
  logic [7:0]        wr_data;
  logic              busy, done, err;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0]        ret_mem [512];
  logic [CFG_AW-1:0] log_a [64];
  logic [7:0]        log_d [64];
  int                log_n = 0;
  int                exp_a [8];
  int                exp_d [8];

  always #5 clk = ~clk;

  wake_patch_seq #(
    .RET_AW (RET_AW), .PTR_LOC (PTR_LOC), .CFG_AW (CFG_AW),
    .CFG_PAGE ('h300), .MAX_ENTRIES (MAXE)
  ) uut (
    .clk (clk), .rst_n (rst_n), .wake_i (wake),
    .ret_rd_en_o (rd_en), .ret_rd_addr_o (rd_addr), .ret_rd_data_i (rd_data),
    .cfg_wr_en_o (wr_en), .cfg_wr_addr_o (wr_addr), .cfg_wr_data_o (wr_data),
    .busy_o (busy), .done_o (done), .err_o (err)
  );

  // retained RAM model: data valid one cycle after the request
  always @(posedge clk) if (rd_en) rd_data <= ret_mem[rd_addr];

  // volatile RAM write log
  always @(posedge clk) if (wr_en && log_n < 64) begin
    log_a[log_n] <= wr_addr;
    log_d[log_n] <= wr_data;
    log_n <= log_n + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  task automatic clear_ret();
    for (int i = 0; i < 512; i++) ret_mem[i] = 8'h00;
  endtask

  // run one patch pass; n writes expected, latency 4n+5 (3 when pointer is 0)
  task automatic run(input string req, input int n, input bit ptr0,
                     input bit exp_err, input int inject_at);
    int cnt;
    int start;
    int lat;
    start = log_n;
    lat = ptr0 ? 3 : 4 * n + 5;
    @(negedge clk) wake = 1'b1;
    @(negedge clk) wake = 1'b0;
    cnt = 1;
    while (!done && cnt < 200) begin
      chk(busy == 1'b1, "R9", "busy during run", busy, 1);
      wake = (cnt == inject_at);
      @(negedge clk);
      cnt++;
    end
    wake = 1'b0;
    chk(cnt == lat, req, "done latency", cnt, lat);
    chk(busy == 1'b0, "R9", "busy in done cycle", busy, 0);
    chk(err == exp_err, req, "err at done", err, exp_err);
    chk(log_n - start == n, req, "write count", log_n - start, n);
    for (int i = 0; i < n && start + i < log_n; i++) begin
      chk(log_a[start+i] == exp_a[i][CFG_AW-1:0], req, "write addr",
          log_a[start+i], exp_a[i]);
      chk(log_d[start+i] == exp_d[i][7:0], req, "write data",
          log_d[start+i], exp_d[i]);
    end
    @(negedge clk);
    chk(done == 1'b0, "R12", "done one cycle", done, 0);
    chk(err == exp_err, "R10", "err held", err, exp_err);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !err && !rd_en && !wr_en, "R1", "outputs in reset",
        {busy, done, err, rd_en, wr_en}, 0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !err && !rd_en && !wr_en, "R1", "outputs after reset",
        {busy, done, err, rd_en, wr_en}, 0);
  endtask

  task automatic load_reference();
    clear_ret();
    ret_mem['h128] = 8'h2B;
    ret_mem['h12B] = 8'h5E; ret_mem['h12C] = 8'h46;
    ret_mem['h12D] = 8'h5F; ret_mem['h12E] = 8'h78;
    ret_mem['h12F] = 8'h2F; ret_mem['h130] = 8'h0F;
    ret_mem['h131] = 8'h00;
    exp_a[0] = 'h35E; exp_d[0] = 'h46;
    exp_a[1] = 'h35F; exp_d[1] = 'h78;
    exp_a[2] = 'h32F; exp_d[2] = 'h0F;
  endtask

  task automatic t_reference();
    // R4 R5 R6: three writes in order, then the terminator
    load_reference();
    @(negedge clk) wake = 1'b1;
    @(negedge clk) wake = 1'b0;
    chk(busy && rd_en && rd_addr == 9'h128, "R2", "pointer read after wake",
        rd_addr, 'h128);
    repeat (20) @(negedge clk);
    load_reference();
    run("R5", 3, 1'b0, 1'b0, 0);
  endtask

  task automatic t_ptr_zero();
    clear_ret();
    ret_mem['h12B] = 8'h5E;
    ret_mem['h12C] = 8'h99;
    run("R3", 0, 1'b1, 1'b0, 0);
  endtask

  task automatic t_full_list();
    // R7: exactly MAXE entries with a terminator ends cleanly
    clear_ret();
    ret_mem['h128] = 8'h40;
    for (int i = 0; i < MAXE; i++) begin
      ret_mem['h140 + 2*i]     = 8'(8'hF0 + i);
      ret_mem['h140 + 2*i + 1] = 8'(8'h10 * (i + 1));
      exp_a[i] = 'h3F0 + i;
      exp_d[i] = 'h10 * (i + 1);
    end
    ret_mem['h140 + 2*MAXE] = 8'h00;
    run("R7", MAXE, 1'b0, 1'b0, 0);
  endtask

  task automatic t_overflow();
    clear_ret();
    ret_mem['h128] = 8'h60;
    for (int i = 0; i <= MAXE; i++) begin
      ret_mem['h160 + 2*i]     = 8'(8'h21 + i);
      ret_mem['h160 + 2*i + 1] = 8'(8'hC0 + i);
      exp_a[i] = 'h321 + i;
      exp_d[i] = 'hC0 + i;
    end
    run("R7", MAXE, 1'b0, 1'b1, 0);
    repeat (3) @(negedge clk);
    chk(err == 1'b1, "R10", "err held while idle", err, 1);
    // next clean run clears the flag
    load_reference();
    run("R10", 3, 1'b0, 1'b0, 0);
  endtask

  task automatic t_wake_busy();
    load_reference();
    run("R8", 3, 1'b0, 1'b0, 6);
  endtask

  task automatic t_wrap();
    // R11: list at 0x1FE continues at 0x000
    clear_ret();
    ret_mem['h128] = 8'hFE;
    ret_mem['h1FE] = 8'h11; ret_mem['h1FF] = 8'hA1;
    ret_mem['h000] = 8'hFF; ret_mem['h001] = 8'hB2;
    ret_mem['h002] = 8'h00;
    exp_a[0] = 'h311; exp_d[0] = 'hA1;
    exp_a[1] = 'h3FF; exp_d[1] = 'hB2;
    run("R11", 2, 1'b0, 1'b0, 0);
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    clear_ret();
    repeat (3) @(negedge clk);
    t_reset();
    t_reference();
    t_ptr_zero();
    t_full_list();
    t_overflow();
    t_wake_busy();
    t_wrap();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule